// File: doc/BRIEF.md
# Key-Protected DRAM Controller Register Bank

This block is the software-visible register file of a DRAM controller. It sits on a simple 32-bit word bus with separate write and read strobes, holds every control word of the controller, and keeps accidental or hostile writes away from those words. The word at byte offset 0x00 is a lock word. Writing one magic value opens the bank. Writing a second magic value seals it until the next reset. Any other value closes it again, but the lock word stays writable.

While the bank is open, some writes are shaped before they are stored. The configuration word at 0x04 keeps its read-only fields and always reports the controller version, the aperture code and a memory-size code that is fixed by a parameter. The PHY status word at 0x60 never reports busy and always reports the PLL as locked. The self-test control word at 0x70 always reports finished and never reports failed. Every other word inside the bank stores its data unchanged.

A write that a lock drops raises a one-cycle violation pulse, which the surrounding logic can turn into an interrupt or an error log. Read data is registered and appears one cycle after the read strobe.

Top module: `dram_cfg_regbank`

## Requirements
- R1: A read with `rd_en` high at a rising edge of `clk` places the addressed word on `rdata` after that edge. `rdata` holds its value until the next read. A read returns the word as stored before any write in the same cycle.
- R2: A permitted write to word 0 with data 0xFC600309 sets the lock word to 0x00000001 (open). Data 0xDEADDEAD sets it to 0x00000010 (sealed). Any other data sets it to 0x00000000 (closed). Reading word 0 returns this lock code.
- R3: While the lock code is 0x10, every in-range write is dropped, including writes to word 0, until reset.
- R4: While the lock code is 0x00, writes to any word other than word 0 are dropped, and word 0 still accepts writes.
- R5: A configuration write (word 1) cannot change bits 31:28, 19, 18:14, 6 or 3:2. The stored word is (data AND NOT 0xF00FC04C) OR the fixed value.
- R6: The fixed configuration value is 0x3 in bits 31:28, 0b11 in bits 3:2, and the size code in bits 1:0. The size code is 0 for 256 MiB, 1 for 512 MiB, 2 for 1024 MiB and 3 for 2048 MiB, taken from parameter `MEM_MIB`.
- R7: A write to byte offset 0x60 stores the data with bit 0 cleared and bit 4 set.
- R8: A write to byte offset 0x70 stores the data with bit 12 set and bit 13 cleared.
- R9: Reset sets every word to zero, except the configuration word, which takes the fixed value. The lock code after reset is 0x00 (closed).
- R10: An access whose address is at or beyond `BANK_BYTES`, or has a nonzero `addr[1:0]`, is out of range. Such a read returns zero, and such a write changes nothing and raises no violation.
- R11: `lock_viol` is high in the cycle after an in-range write that a lock dropped, and low after any other cycle.
- R12: A permitted write to any other in-range word stores the 32-bit data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| lock_viol | output | 1 | One-cycle pulse after a write dropped by a lock |

## Verification
The bench builds the bank with `MEM_MIB` = 2048, so the size code is all ones. This exposes the case where written bits 1:0 are ORed with the code and cannot clear it. `ADDR_W` is 16 while the bank spans 4096 bytes, so addresses past the bank, such as 0x1000 and 0x1004, can be reached. The 0x1004 case checks that an out-of-range write does not alias onto the configuration word. A second reset in the middle of the run checks that the sealed state does end at reset and that the stored words clear.

// File: rtl/dcrb_pkg.sv
package dcrb_pkg;

   typedef enum logic [1:0] {
      LK_CLOSED = 2'd0,
      LK_OPEN   = 2'd1,
      LK_SEALED = 2'd2
   } lock_e;

   localparam logic [31:0] KEY_OPEN    = 32'hFC60_0309;
   localparam logic [31:0] KEY_SEAL    = 32'hDEAD_DEAD;
   localparam logic [31:0] CODE_CLOSED = 32'h0000_0000;
   localparam logic [31:0] CODE_OPEN   = 32'h0000_0001;
   localparam logic [31:0] CODE_SEALED = 32'h0000_0010;

   // word indices (byte offset / 4); software decodes these positions
   localparam int W_LOCK = 0;
   localparam int W_CFG  = 1;
   localparam int W_PHY  = 'h60 / 4;
   localparam int W_TEST = 'h70 / 4;

   // protected configuration fields: version, init flag, reserved, bit 6, aperture
   localparam logic [31:0] CFG_RO_MASK = 32'hF00F_C04C;
   localparam logic [31:0] CFG_BASE    = 32'h3000_000C;

   localparam logic [31:0] PHY_CLR = 32'h0000_0001;
   localparam logic [31:0] PHY_SET = 32'h0000_0010;
   localparam logic [31:0] TST_SET = 32'h0000_1000;
   localparam logic [31:0] TST_CLR = 32'h0000_2000;

   function automatic logic [1:0] size_code(input int mib);
      case (mib)
         256:     return 2'd0;
         512:     return 2'd1;
         1024:    return 2'd2;
         default: return 2'd3;
      endcase
   endfunction

   function automatic logic [31:0] lock_code(input lock_e st);
      case (st)
         LK_OPEN:   return CODE_OPEN;
         LK_SEALED: return CODE_SEALED;
         default:   return CODE_CLOSED;
      endcase
   endfunction

endpackage

// File: rtl/dcrb_lock_ctrl.sv
module dcrb_lock_ctrl
   import dcrb_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_hit,
   input  logic        is_lock_word,
   input  logic [31:0] wdata,
   output lock_e       state,
   output logic        permit,
   output logic        viol_o
);

   lock_e nxt;

   always_comb begin
      case (state)
         LK_OPEN:   permit = 1'b1;
         LK_CLOSED: permit = is_lock_word;
         default:   permit = 1'b0;
      endcase
   end

   always_comb begin
      if (wdata == KEY_OPEN)      nxt = LK_OPEN;
      else if (wdata == KEY_SEAL) nxt = LK_SEALED;
      else                        nxt = LK_CLOSED;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= LK_CLOSED;
         viol_o <= 1'b0;
      end else begin
         if (wr_hit && permit && is_lock_word) state <= nxt;
         viol_o <= wr_hit && !permit;
      end
   end

   // R3: the sealed state persists until reset
   p_sealed_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      state == LK_SEALED |=> state == LK_SEALED);

   // R11: no violation can follow a cycle in which the bank was open
   p_open_no_viol_r11: assert property (@(posedge clk) disable iff (!rst_n)
      state == LK_OPEN |=> !viol_o);

endmodule

// File: rtl/dcrb_shaper.sv
module dcrb_shaper
   import dcrb_pkg::*;
#(
   parameter int         IDX_W     = 10,
   parameter logic [1:0] SIZE_CODE = 2'd1
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [31:0]      wdata,
   output logic [31:0]      shaped
);

   localparam logic [31:0] CFG_FIXED = CFG_BASE | {30'd0, SIZE_CODE};

   always_comb begin
      case (int'(idx))
         W_CFG:   shaped = (wdata & ~CFG_RO_MASK) | CFG_FIXED;
         W_PHY:   shaped = (wdata & ~PHY_CLR) | PHY_SET;
         W_TEST:  shaped = (wdata & ~TST_CLR) | TST_SET;
         default: shaped = wdata;
      endcase
   end

endmodule

// File: rtl/dcrb_store.sv
module dcrb_store
   import dcrb_pkg::*;
#(
   parameter int          NUM_WORDS = 1024,
   parameter int          IDX_W     = 10,
   parameter logic [31:0] CFG_RESET = 32'h3000_000D
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [31:0]      wd,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [31:0]      rd_word,
   output logic [31:0]      cfg_q,
   output logic [31:0]      phy_q
);

   logic [31:0] words [NUM_WORDS];

   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
      localparam logic [31:0] RST_VAL = (g == W_CFG) ? CFG_RESET : 32'd0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          words[g] <= RST_VAL;
         else if (we && int'(wr_idx) == g)    words[g] <= wd;
      end
   end

   assign rd_word = words[rd_idx];
   assign cfg_q   = words[W_CFG];
   assign phy_q   = words[W_PHY];

endmodule

// File: rtl/dram_cfg_regbank.sv
module dram_cfg_regbank
   import dcrb_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int BANK_BYTES = 4096,
   parameter int MEM_MIB    = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              lock_viol
);

   localparam int          NUM_WORDS = BANK_BYTES / 4;
   localparam int          IDX_W     = $clog2(NUM_WORDS);
   localparam logic [1:0]  SIZE_CODE = size_code(MEM_MIB);
   localparam logic [31:0] CFG_RESET = CFG_BASE | {30'd0, SIZE_CODE};

   if ((BANK_BYTES & (BANK_BYTES - 1)) != 0 || BANK_BYTES < 128) begin : g_bad_bank
      $error("BANK_BYTES must be a power of two of at least 128");
   end
   if (ADDR_W < IDX_W + 2) begin : g_bad_addr
      $error("ADDR_W too narrow for BANK_BYTES");
   end
   if (MEM_MIB != 256 && MEM_MIB != 512 && MEM_MIB != 1024 && MEM_MIB != 2048) begin : g_bad_size
      $error("MEM_MIB must be 256, 512, 1024 or 2048");
   end

   logic             in_range;
   logic [IDX_W-1:0] idx;
   logic             wr_hit;
   logic             is_lock;
   lock_e            lk_state;
   logic             permit;
   logic [31:0]      shaped;
   logic [31:0]      rd_word;
   logic [31:0]      cfg_q;
   logic [31:0]      phy_q;

   assign in_range = ({1'b0, addr} < (ADDR_W + 1)'(BANK_BYTES)) && (addr[1:0] == 2'b00);
   assign idx      = addr[IDX_W+1:2];
   assign wr_hit   = wr_en && in_range;
   assign is_lock  = (int'(idx) == W_LOCK);

   dcrb_lock_ctrl u_lock (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_hit       (wr_hit),
      .is_lock_word (is_lock),
      .wdata        (wdata),
      .state        (lk_state),
      .permit       (permit),
      .viol_o       (lock_viol)
   );

   dcrb_shaper #(
      .IDX_W     (IDX_W),
      .SIZE_CODE (SIZE_CODE)
   ) u_shape (
      .idx    (idx),
      .wdata  (wdata),
      .shaped (shaped)
   );

   dcrb_store #(
      .NUM_WORDS (NUM_WORDS),
      .IDX_W     (IDX_W),
      .CFG_RESET (CFG_RESET)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_hit && permit && !is_lock),
      .wr_idx  (idx),
      .wd      (shaped),
      .rd_idx  (idx),
      .rd_word (rd_word),
      .cfg_q   (cfg_q),
      .phy_q   (phy_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rdata <= 32'd0;
      else if (rd_en) begin
         if (!in_range)    rdata <= 32'd0;
         else if (is_lock) rdata <= lock_code(lk_state);
         else              rdata <= rd_word;
      end
   end

   // R4: a closed bank leaves the configuration word untouched
   p_closed_cfg_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_state == LK_CLOSED && wr_en && in_range && int'(idx) == W_CFG) |=> $stable(cfg_q));

   // R5: protected configuration fields never leave their fixed values
   p_cfg_protected_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[31:28] == 4'h3 && cfg_q[3:2] == 2'b11 && cfg_q[19:14] == 6'd0 && !cfg_q[6]);

   // R6: the size code bits are always present
   p_cfg_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[1:0] & SIZE_CODE) == SIZE_CODE);

   // R7: the PHY status word never reports busy
   p_phy_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !phy_q[0]);

   // R10: an out-of-range read yields zero
   p_oor_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !in_range) |=> rdata == 32'd0);

endmodule

// File: tb/dram_cfg_regbank_bench.sv
`timescale 1ns/1ps
module dram_cfg_regbank_bench;

   localparam logic [31:0] FIXED = 32'h3000_000F;
   localparam logic [31:0] ROM   = 32'hF00F_C04C;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en, rd_en;
   logic [15:0] addr;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic        lock_viol;

   int n_chk  = 0;
   int n_fail = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        mon_due = 1'b0;

   always #2 clk = ~clk;

   dram_cfg_regbank #(
      .ADDR_W     (16),
      .BANK_BYTES (4096),
      .MEM_MIB    (2048)
   ) u_dram_cfg_regbank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .addr      (addr),
      .wdata     (wdata),
      .rdata     (rdata),
      .lock_viol (lock_viol)
   );

   function automatic logic [31:0] cfg_exp(input logic [31:0] d);
      return (d & ~ROM) | FIXED;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   // monitor: a read sampled at a rising edge is compared at the following falling edge
   always @(posedge clk) mon_due <= rd_en;

   always @(negedge clk) begin
      if (mon_due) begin
         if (exp_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1: read result with no expected item, actual %08h expected none", rdata);
         end else begin
            check(tag_q.pop_front(), rdata, exp_q.pop_front());
         end
      end
   end

   task automatic do_read(input logic [15:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      rd_en = 1'b1;
      addr  = a;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic do_write(input logic [15:0] a, input logic [31:0] d,
                           input logic exp_viol, input string tag);
      @(negedge clk);
      wr_en = 1'b1;
      addr  = a;
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      check({tag, " violation pulse"}, {31'd0, lock_viol}, {31'd0, exp_viol});
   endtask

   task automatic pulse_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #80000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      wr_en = 1'b0;
      rd_en = 1'b0;
      addr  = '0;
      wdata = '0;
      repeat (3) @(negedge clk);
      check("R9 rdata at reset", rdata, 32'd0);
      rst_n = 1'b1;

      // reset state
      do_read(16'h0000, 32'h0000_0000, "R9 lock closed after reset");
      do_read(16'h0004, FIXED,         "R9 R6 config reset value");
      do_read(16'h0060, 32'h0000_0000, "R9 status zero");
      do_read(16'h0100, 32'h0000_0000, "R9 plain word zero");

      // closed bank drops data writes
      do_write(16'h0100, 32'h1234_5678, 1'b1, "R4 R11 closed write");
      do_read(16'h0100, 32'h0000_0000, "R4 closed write dropped");

      // open
      do_write(16'h0000, 32'hFC60_0309, 1'b0, "R2 open key");
      do_read(16'h0000, 32'h0000_0001, "R2 open code");
      do_write(16'h0100, 32'hA5A5_5A5A, 1'b0, "R12 plain write");
      do_read(16'h0100, 32'hA5A5_5A5A, "R12 plain readback");
      do_write(16'h0FFC, 32'h0BAD_F00D, 1'b0, "R12 last word write");
      do_read(16'h0FFC, 32'h0BAD_F00D, "R12 last word readback");

      // configuration shaping
      do_write(16'h0004, 32'hFFFF_FFFF, 1'b0, "R5 cfg all ones");
      do_read(16'h0004, cfg_exp(32'hFFFF_FFFF), "R5 cfg all ones");
      do_write(16'h0004, 32'h0000_0000, 1'b0, "R6 cfg zero");
      do_read(16'h0004, FIXED, "R6 cfg zero keeps fixed");
      do_write(16'h0004, 32'h0000_0120, 1'b0, "R5 cfg writable bits");
      do_read(16'h0004, 32'h3000_012F, "R5 cfg writable bits");

      // status and self-test shaping
      do_write(16'h0060, 32'hFFFF_FFFF, 1'b0, "R7 status ones");
      do_read(16'h0060, 32'hFFFF_FFFE, "R7 busy cleared");
      do_write(16'h0060, 32'h0000_0000, 1'b0, "R7 status zero");
      do_read(16'h0060, 32'h0000_0010, "R7 pll lock set");
      do_write(16'h0070, 32'hFFFF_FFFF, 1'b0, "R8 test ones");
      do_read(16'h0070, 32'hFFFF_DFFF, "R8 fail cleared");
      do_write(16'h0070, 32'h0000_0000, 1'b0, "R8 test zero");
      do_read(16'h0070, 32'h0000_1000, "R8 finished set");

      // out of range
      do_write(16'h1004, 32'hFFFF_FFFF, 1'b0, "R10 oor write");
      do_read(16'h0004, 32'h3000_012F, "R10 no alias onto cfg");
      do_read(16'h1000, 32'h0000_0000, "R10 oor read");
      do_write(16'h0102, 32'h5555_5555, 1'b0, "R10 misaligned write");
      do_read(16'h0100, 32'hA5A5_5A5A, "R10 misaligned write ignored");
      do_read(16'h0101, 32'h0000_0000, "R10 misaligned read");

      // re-close, lock word stays writable
      do_write(16'h0000, 32'h0000_1234, 1'b0, "R2 other value");
      do_read(16'h0000, 32'h0000_0000, "R2 closed code");
      do_write(16'h0060, 32'h0000_0020, 1'b1, "R4 R11 closed status write");
      do_read(16'h0060, 32'h0000_0010, "R4 status unchanged");
      do_write(16'h1000, 32'h0, 1'b0, "R10 R11 oor write while closed");

      // seal
      do_write(16'h0000, 32'hDEAD_DEAD, 1'b0, "R2 seal key");
      do_read(16'h0000, 32'h0000_0010, "R2 sealed code");
      do_write(16'h0000, 32'hFC60_0309, 1'b1, "R3 R11 open key while sealed");
      do_read(16'h0000, 32'h0000_0010, "R3 stays sealed");
      do_write(16'h0100, 32'h0, 1'b1, "R3 R11 data write while sealed");
      do_read(16'h0100, 32'hA5A5_5A5A, "R3 data unchanged");

      // reset ends the seal and clears words
      pulse_reset();
      do_read(16'h0000, 32'h0000_0000, "R9 R3 reset ends seal");
      do_read(16'h0100, 32'h0000_0000, "R9 word cleared");
      do_read(16'h0004, FIXED,         "R9 cfg back to fixed");
      do_read(16'h0070, 32'h0000_0000, "R9 test cleared");

      // same-cycle read and write: read sees old value
      do_write(16'h0000, 32'hFC60_0309, 1'b0, "R2 reopen");
      @(negedge clk);
      wr_en = 1'b1;
      rd_en = 1'b1;
      addr  = 16'h0200;
      wdata = 32'hCAFE_0001;
      exp_q.push_back(32'h0000_0000);
      tag_q.push_back("R1 read before write");
      @(negedge clk);
      wr_en = 1'b0;
      rd_en = 1'b0;
      do_read(16'h0200, 32'hCAFE_0001, "R1 R12 written value");
      check("R1 rdata held", rdata, 32'hCAFE_0001);

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1: %0d reads unanswered, expected 0", exp_q.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule